// File: doc/BRIEF.md
# Add-Only EPROM Command Engine with CRC16

This block is the byte-level command engine of a one-time-programmable memory that sits behind a serial bus. A bit layer outside this block delivers received bytes and asks for bytes to send. The engine starts work once an external selection strobe says the device has been addressed. It then decodes a command byte and a two-byte start address. After that it streams data, status bytes and check words, or it takes in a byte to be programmed. Programming can only clear bits: each program strobe combines the old byte and the new byte with a bitwise AND.

Storage is split in two. The data array holds a parameterised number of 32-byte pages and is indexed by the low bits of a 13-bit address counter. The status array holds three things: a protection bit per data page, a protection bit per page-redirect byte, and one redirect byte per page. Any status address outside those windows reads back as all ones and cannot be written. A CRC16 generator runs alongside the transfer. Each command clears, loads or shifts it at fixed points, so the bus master can check every segment of the exchange. A bus reset pulse aborts any command at any time.

Top module: `eprom_cmd_engine`

## Requirements
- R1: Command codes: F0h streams the data array, AAh streams the status array, A5h does a paged read with redirect bytes, 0Fh or F3h programs the data array, and 55h or F5h programs the status array. Each code is followed by the low address byte and then the high address byte. The counter keeps only bits 4:0 of the high byte, and the data array uses the low log2(depth) bits of the counter. Any other code sends the engine back to waiting for selection.
- R2: The check word starts at zero after selection. Every byte is shifted in LSB first with the reflected polynomial x^16+x^15+x^2+1 (mask A001h). The word is sent bit-inverted, low byte first. A byte request is answered on tx_byte in the cycle after it, with tx_valid high for that one cycle.
- R3: F0h sends data from the start index up to the last index. It then sends the check word over command, both address bytes and every byte sent, and FFh after that.
- R4: AAh sends status bytes up to an address ending in 7 and then sends a check word. The first word also covers command and address. Each later word is cleared first and covers only that 8-byte group. After the group that holds 1FFh, or any higher group, the engine sends FFh.
- R5: A5h first sends the redirect byte of the current page, found at status 100h plus the page number, and then a check word. The first such word covers command, address and redirect byte. Later ones cover the redirect byte alone.
- R6: After the redirect check word, A5h sends data up to the page end, then a check word over only those data bytes. It then moves to the next page's redirect byte. After the last page it sends FFh.
- R7: In a checked write, the received data byte is followed by a check word. On the first pass this word covers command, address and data. On later passes the generator is first loaded with the incremented 16-bit address and then the data is shifted in.
- R8: F3h and F5h send no check word. The program strobe is accepted right after the data byte.
- R9: A program strobe stores old AND new. The next byte request returns the stored byte, and the counter then always increments. Past the last data index (for a data write) or past status 1FFh (for a status write), the engine sends FFh.
- R10: A data page p is protected when bit p mod 8 of status byte p/8 is 0. A program strobe to a protected page leaves the byte unchanged.
- R11: The redirect byte of page p is protected when bit p mod 8 of status byte 20h + p/8 is 0.
- R12: Status addresses 060h–0FFh and 200h and up read as FFh and ignore program strobes.
- R13: Out of reset, tx_byte is FFh and tx_valid is 0. A bus reset pulse at any point aborts the command. Before selection, received bytes are ignored and every byte request returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Device-selected strobe, starts a command |
| abort | input | 1 | Bus reset pulse, aborts the command |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next byte to send |
| prog | input | 1 | Program pulse strobe |
| tx_byte | output | 8 | Byte to send, registered |
| tx_valid | output | 1 | tx_byte answers the previous request |

## Verification
The data array is first filled completely with speed writes of an arithmetic pattern. It is then streamed back from index 0 and from a mid-array start whose high address byte carries junk. This separates wrong data from wrong coverage of the check word. The status array is read from a start inside a group, across the unimplemented hole and up to the end, which shows the first-pass and cleared check words and the all-ones regions. Paged reads run once a redirect byte has been programmed, so first-pass and later-pass redirect words differ. Writes into protected and unprotected pages, and into protected and unprotected redirect bytes, show whether the protection lookup blocks the right byte while the counter still steps.

// File: rtl/eprom_eng_pkg.sv
package eprom_eng_pkg;
  localparam int ADDR_W = 13;

  localparam logic [7:0] OP_RD_DATA   = 8'hF0;
  localparam logic [7:0] OP_RD_STAT   = 8'hAA;
  localparam logic [7:0] OP_RD_PAGED  = 8'hA5;
  localparam logic [7:0] OP_WR_DATA   = 8'h0F;
  localparam logic [7:0] OP_WR_DATA_F = 8'hF3;
  localparam logic [7:0] OP_WR_STAT   = 8'h55;
  localparam logic [7:0] OP_WR_STAT_F = 8'hF5;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADL, S_ADH, S_RDATA, S_REDIR,
    S_CRCL, S_CRCH, S_WDATA, S_WPROG, S_WVER, S_ONES
  } state_t;

  typedef enum logic [2:0] {K_RDMEM, K_RDSTAT, K_EXT, K_WMEM, K_WSTAT} kind_t;

  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eprom_data_array.sv
module eprom_data_array #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    mask,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= mem[addr] & mask;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/eprom_status_array.sv
module eprom_status_array #(
  parameter int PROT_BYTES  = 32,
  parameter int USED_BYTES  = 32,
  parameter int REDIR_BYTES = 256
) (
  input  logic        clk,
  input  logic        we,
  input  logic [12:0] waddr,
  input  logic [7:0]  mask,
  input  logic [12:0] raddr,
  output logic [7:0]  rdata,
  input  logic [7:0]  dp_page,
  input  logic [7:0]  rp_page,
  output logic        data_prot,
  output logic        redir_prot
);
  localparam int LOW_BYTES = 2 * PROT_BYTES + USED_BYTES;
  localparam int SLOTS     = LOW_BYTES + REDIR_BYTES;
  localparam int SW        = $clog2(SLOTS);

  logic [7:0] mem [SLOTS];
  logic [7:0] dp_byte, rp_byte;

  function automatic logic impl(input logic [12:0] a);
    return (a < 13'(LOW_BYTES)) || (a[12:8] == 5'h01);
  endfunction

  function automatic logic [SW-1:0] slot(input logic [12:0] a);
    if (a < 13'(LOW_BYTES)) return SW'(a);
    return SW'(LOW_BYTES) + SW'(a[7:0]);
  endfunction

  initial begin
    for (int i = 0; i < SLOTS; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we && impl(waddr)) mem[slot(waddr)] <= mem[slot(waddr)] & mask;
  end

  assign rdata      = impl(raddr) ? mem[slot(raddr)] : 8'hFF;
  assign dp_byte    = mem[SW'(dp_page[7:3])];
  assign rp_byte    = mem[SW'(PROT_BYTES) + SW'(rp_page[7:3])];
  assign data_prot  = ~dp_byte[dp_page[2:0]];
  assign redir_prot = ~rp_byte[rp_page[2:0]];
endmodule

// File: rtl/eprom_cmd_engine.sv
module eprom_cmd_engine #(
  parameter int PAGES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       abort,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  input  logic       prog,
  output logic [7:0] tx_byte,
  output logic       tx_valid
);
  import eprom_eng_pkg::*;

  localparam int DEPTH = PAGES * 32;
  localparam int DAW   = $clog2(DEPTH);
  localparam int PGW   = DAW - 5;

  state_t             state;
  kind_t              kind;
  logic               speed;
  logic               redir_pass;
  logic [ADDR_W-1:0]  addr;
  logic [7:0]         adl;
  logic [15:0]        crc;
  logic [7:0]         scratch;

  logic [DAW-1:0]     idx;
  logic [PGW-1:0]     page;
  logic [7:0]         page8;
  logic [7:0]         dm_rdata, st_rdata, send_byte;
  logic [12:0]        st_raddr;
  logic               dm_we, st_we, data_prot, redir_prot;
  logic               last_idx, last_page, is_redir, busy;

  assign idx       = addr[DAW-1:0];
  assign page      = idx[DAW-1:5];
  assign page8     = {{(8-PGW){1'b0}}, page};
  assign last_idx  = &idx;
  assign last_page = &page;
  assign is_redir  = (addr[12:8] == 5'h01);
  assign busy      = abort | sel;
  assign st_raddr  = (state == S_REDIR) ? (13'h100 | {5'b0, page8}) : addr;

  assign dm_we = (state == S_WPROG) && prog && !busy && (kind == K_WMEM) && !data_prot;
  assign st_we = (state == S_WPROG) && prog && !busy && (kind == K_WSTAT) &&
                 !(is_redir && redir_prot);

  eprom_data_array #(.DEPTH(DEPTH), .AW(DAW)) u_dmem (
    .clk(clk), .we(dm_we), .addr(idx), .mask(scratch), .rdata(dm_rdata)
  );

  eprom_status_array u_smem (
    .clk(clk), .we(st_we), .waddr(addr), .mask(scratch), .raddr(st_raddr),
    .rdata(st_rdata), .dp_page(page8), .rp_page(addr[7:0]),
    .data_prot(data_prot), .redir_prot(redir_prot)
  );

  always_comb begin
    case (state)
      S_RDATA: send_byte = (kind == K_RDSTAT) ? st_rdata : dm_rdata;
      S_REDIR: send_byte = st_rdata;
      S_CRCL:  send_byte = ~crc[7:0];
      S_CRCH:  send_byte = ~crc[15:8];
      S_WVER:  send_byte = (kind == K_WMEM) ? dm_rdata : st_rdata;
      default: send_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      kind       <= K_RDMEM;
      speed      <= 1'b0;
      redir_pass <= 1'b0;
      addr       <= '0;
      adl        <= '0;
      crc        <= '0;
      scratch    <= 8'hFF;
      tx_byte    <= 8'hFF;
      tx_valid   <= 1'b0;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_byte <= send_byte;
      if (abort) begin
        state <= S_IDLE;
      end else if (sel) begin
        state <= S_CMD;
        crc   <= '0;
      end else begin
        case (state)
          S_CMD: if (rx_valid) begin
            crc   <= crc16_next(crc, rx_byte);
            state <= S_ADL;
            speed <= (rx_byte == OP_WR_DATA_F) || (rx_byte == OP_WR_STAT_F);
            case (rx_byte)
              OP_RD_DATA:                 kind <= K_RDMEM;
              OP_RD_STAT:                 kind <= K_RDSTAT;
              OP_RD_PAGED:                kind <= K_EXT;
              OP_WR_DATA, OP_WR_DATA_F:   kind <= K_WMEM;
              OP_WR_STAT, OP_WR_STAT_F:   kind <= K_WSTAT;
              default:                    state <= S_IDLE;
            endcase
          end
          S_ADL: if (rx_valid) begin
            adl   <= rx_byte;
            crc   <= crc16_next(crc, rx_byte);
            state <= S_ADH;
          end
          S_ADH: if (rx_valid) begin
            addr <= {rx_byte[4:0], adl};
            crc  <= crc16_next(crc, rx_byte);
            case (kind)
              K_EXT:            state <= S_REDIR;
              K_WMEM, K_WSTAT:  state <= S_WDATA;
              default:          state <= S_RDATA;
            endcase
          end
          S_RDATA: if (tx_req) begin
            crc <= crc16_next(crc, send_byte);
            case (kind)
              K_RDMEM:  if (last_idx) state <= S_CRCL; else addr <= addr + 13'd1;
              K_RDSTAT: if (&addr[2:0]) state <= S_CRCL; else addr <= addr + 13'd1;
              default: begin
                if (&addr[4:0]) begin
                  state      <= S_CRCL;
                  redir_pass <= 1'b0;
                end else addr <= addr + 13'd1;
              end
            endcase
          end
          S_REDIR: if (tx_req) begin
            crc        <= crc16_next(crc, send_byte);
            redir_pass <= 1'b1;
            state      <= S_CRCL;
          end
          S_CRCL: if (tx_req) state <= S_CRCH;
          S_CRCH: if (tx_req) begin
            case (kind)
              K_RDMEM: state <= S_ONES;
              K_RDSTAT: begin
                if (addr[12:3] >= 10'h03F) state <= S_ONES;
                else begin
                  addr  <= addr + 13'd1;
                  crc   <= '0;
                  state <= S_RDATA;
                end
              end
              K_EXT: begin
                if (redir_pass) begin
                  crc   <= '0;
                  state <= S_RDATA;
                end else if (last_page) state <= S_ONES;
                else begin
                  addr  <= addr + 13'd1;
                  crc   <= '0;
                  state <= S_REDIR;
                end
              end
              default: state <= S_WPROG;
            endcase
          end
          S_WDATA: if (rx_valid) begin
            scratch <= rx_byte;
            crc     <= crc16_next(crc, rx_byte);
            state   <= speed ? S_WPROG : S_CRCL;
          end
          S_WPROG: if (prog) state <= S_WVER;
          S_WVER: if (tx_req) begin
            if ((kind == K_WMEM) ? last_idx : (addr == 13'h1FF)) state <= S_ONES;
            else begin
              addr  <= addr + 13'd1;
              crc   <= {3'b0, addr + 13'd1};
              state <= S_WDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eprom_cmd_chk.sv
module eprom_cmd_chk (
  input logic                  clk,
  input logic                  rst,
  input logic                  abort,
  input logic                  sel,
  input logic                  tx_req,
  input logic                  rx_valid,
  input logic                  speed,
  input eprom_eng_pkg::state_t state,
  input eprom_eng_pkg::kind_t  kind,
  input logic [15:0]           crc,
  input logic [12:0]           addr,
  input logic [7:0]            tx_byte,
  input logic                  dm_we,
  input logic                  data_prot,
  input logic [12:0]           st_raddr,
  input logic [7:0]            st_rdata
);
  import eprom_eng_pkg::*;

  assert_idle_after_abort_R13: assert property (@(posedge clk) disable iff (rst)
    abort |=> state == S_IDLE);

  assert_crc_low_inverted_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_CRCL && tx_req) |=> tx_byte == ~$past(crc[7:0]));

  assert_speed_skips_crc_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_WDATA && rx_valid && speed && !abort && !sel) |=> state == S_WPROG);

  assert_protected_page_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (data_prot && kind == K_WMEM) |-> !dm_we);

  assert_unimpl_reads_ones_R12: assert property (@(posedge clk) disable iff (rst)
    !((st_raddr < 13'h060) || (st_raddr[12:8] == 5'h01)) |-> st_rdata == 8'hFF);

  assert_addr_steps_after_verify_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_WVER && tx_req && !abort && !sel)
      |=> (addr == $past(addr) + 13'd1) || (state == S_ONES));
endmodule

bind eprom_cmd_engine eprom_cmd_chk u_chk (
  .clk(clk), .rst(rst), .abort(abort), .sel(sel), .tx_req(tx_req),
  .rx_valid(rx_valid), .speed(speed), .state(state), .kind(kind), .crc(crc),
  .addr(addr), .tx_byte(tx_byte), .dm_we(dm_we), .data_prot(data_prot),
  .st_raddr(st_raddr), .st_rdata(st_rdata)
);

// File: tb/sim_eprom_cmd_engine.sv
`timescale 1ns/1ps
module sim_eprom_cmd_engine;
  logic clk = 1'b0, rst = 1'b1, sel = 1'b0, abort = 1'b0;
  logic rx_valid = 1'b0, tx_req = 1'b0, prog = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_byte;
  logic tx_valid;

  int checks = 0, fails = 0;
  logic [7:0]  dm [256];
  logic [7:0]  sm [512];
  logic [15:0] mc;
  logic [7:0]  b;
  bit          finished = 0;

  always #4 clk = ~clk;

  eprom_cmd_engine #(.PAGES(8)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .abort(abort), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .prog(prog), .tx_byte(tx_byte), .tx_valid(tx_valid)
  );

  function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] exp_st(input int a);
    if (a < 'h60 || (a >= 'h100 && a < 'h200)) return sm[a];
    return 8'hFF;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic get(output logic [7:0] v);
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
    v = tx_byte;
  endtask

  task automatic put(input logic [7:0] v);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = v; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic pulse_sel;   @(negedge clk) sel = 1'b1;   @(negedge clk) sel = 1'b0;   endtask
  task automatic pulse_abort; @(negedge clk) abort = 1'b1; @(negedge clk) abort = 1'b0; endtask
  task automatic pulse_prog;  @(negedge clk) prog = 1'b1;  @(negedge clk) prog = 1'b0;  endtask

  task automatic start(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi);
    pulse_sel; put(cmd); put(lo); put(hi);
    mc = m_crc(m_crc(m_crc(16'h0, cmd), lo), hi);
  endtask

  task automatic exp_crc(input string tag, input logic [15:0] c);
    logic [7:0] v;
    get(v); check8(tag, v, ~c[7:0]);
    get(v); check8(tag, v, ~c[15:8]);
  endtask

  task automatic wr_step(input bit stat, input bit speed, input int a, input logic [7:0] d,
                         input string tag);
    logic [7:0] e, v;
    int i, pg;
    put(d);
    mc = m_crc(mc, d);
    if (!speed) exp_crc(tag, mc);
    pulse_prog;
    if (!stat) begin
      i = a & 255; pg = i >> 5;
      if (sm[pg >> 3][pg & 7]) dm[i] = dm[i] & d;
      e = dm[i];
    end else begin
      if (a < 'h60) sm[a] = sm[a] & d;
      else if (a >= 'h100 && a < 'h200) begin
        if (sm['h20 + ((a & 255) >> 3)][a & 7]) sm[a] = sm[a] & d;
      end
      e = exp_st(a);
    end
    get(v);
    check8(tag, v, e);
    mc = 16'((a + 1) & 16'h1FFF);
  endtask

  task automatic rd_mem(input logic [7:0] lo, input logic [7:0] hi, input string tag);
    logic [7:0] v;
    start(8'hF0, lo, hi);
    for (int i = int'(lo); i < 256; i++) begin
      get(v); check8(tag, v, dm[i]); mc = m_crc(mc, dm[i]);
    end
    exp_crc(tag, mc);
    get(v); check8(tag, v, 8'hFF);
  endtask

  task automatic rd_stat(input int s);
    logic [7:0] v;
    int a = s;
    start(8'hAA, 8'(s & 255), 8'(s >> 8));
    forever begin
      get(v); check8("R4", v, exp_st(a)); mc = m_crc(mc, exp_st(a));
      if ((a & 7) == 7) begin
        exp_crc("R4", mc);
        if (a >= 'h1F8) break;
        mc = 16'h0;
      end
      a++;
    end
    get(v); check8("R4 ones", v, 8'hFF);
  endtask

  task automatic rd_paged(input int s);
    logic [7:0] v, r;
    bit first = 1;
    start(8'hA5, 8'(s), 8'h00);
    for (int p = s >> 5; p < 8; p++) begin
      r = sm['h100 + p];
      get(v); check8("R5 redirect", v, r);
      mc = first ? m_crc(mc, r) : m_crc(16'h0, r);
      exp_crc("R5", mc);
      mc = 16'h0;
      for (int i = (first ? s : p * 32); i < p * 32 + 32; i++) begin
        get(v); check8("R6 data", v, dm[i]); mc = m_crc(mc, dm[i]);
      end
      exp_crc("R6", mc);
      first = 0;
    end
    get(v); check8("R6 ones", v, 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) dm[i] = 8'hFF;
    for (int i = 0; i < 512; i++) sm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check8("R13 reset byte", tx_byte, 8'hFF);
    check8("R13 reset valid", {7'b0, tx_valid}, 8'h00);
    put(8'hF0); put(8'h00); put(8'h00);
    get(b); check8("R13 unselected", b, 8'hFF);
    check8("R2 valid", {7'b0, tx_valid}, 8'h01);

    // R8 / R9: fill the whole array with speed writes
    start(8'hF3, 8'h00, 8'h00);
    for (int i = 0; i < 256; i++) wr_step(0, 1, i, pat(i), "R8");
    get(b); check8("R9 end ones", b, 8'hFF);

    rd_mem(8'h00, 8'h00, "R3");
    rd_mem(8'hF0, 8'hE1, "R1 high bits");      // counter 1F0h, index F0h

    // R7: checked write, first and later pass
    start(8'h0F, 8'h23, 8'h00);
    wr_step(0, 0, 'h23, 8'hA5, "R7");
    wr_step(0, 0, 'h24, 8'h3C, "R7");
    pulse_abort;
    start(8'h0F, 8'h23, 8'h00);
    wr_step(0, 0, 'h23, 8'h0F, "R9 and");
    pulse_abort;

    rd_stat('h5E);

    // redirect byte of page 0, then protect data page 2
    start(8'h55, 8'h00, 8'h01);
    wr_step(1, 0, 'h100, 8'hFD, "R11 open");
    pulse_abort;
    start(8'h55, 8'h00, 8'h00);
    wr_step(1, 0, 'h000, 8'hFB, "R10 set");
    pulse_abort;
    start(8'h0F, 8'h40, 8'h00);
    wr_step(0, 0, 'h40, 8'h00, "R10 blocked");
    wr_step(0, 0, 'h41, 8'h00, "R10 blocked");
    pulse_abort;
    start(8'h0F, 8'h60, 8'h00);
    wr_step(0, 0, 'h60, 8'h00, "R10 open page");
    pulse_abort;

    // R11: protect redirect byte of page 0 only
    start(8'h55, 8'h20, 8'h00);
    wr_step(1, 0, 'h20, 8'hFE, "R11 set");
    pulse_abort;
    start(8'h55, 8'h00, 8'h01);
    wr_step(1, 0, 'h100, 8'h00, "R11 blocked");
    wr_step(1, 0, 'h101, 8'h7F, "R11 open");
    pulse_abort;

    // R12: unimplemented status
    start(8'h55, 8'h80, 8'h00);
    wr_step(1, 0, 'h80, 8'h00, "R12 hole");
    pulse_abort;
    start(8'hF5, 8'h05, 8'h02);
    wr_step(1, 1, 'h205, 8'h00, "R12 above");
    pulse_abort;

    rd_paged(5);

    // R13: abort mid-stream, bytes before new selection ignored
    start(8'hF0, 8'h00, 8'h00);
    get(b); check8("R13 pre", b, dm[0]);
    pulse_abort;
    put(8'hF0); put(8'h10); put(8'h00);
    get(b); check8("R13 after abort", b, 8'hFF);
    start(8'hF0, 8'h10, 8'h00);
    get(b); check8("R13 reselect", b, dm['h10]);
    pulse_abort;

    // R1: unknown command
    pulse_sel; put(8'h33); put(8'h00); put(8'h00);
    get(b); check8("R1 unknown", b, 8'hFF);
    get(b); check8("R1 unknown", b, 8'hFF);

    rd_mem(8'h00, 8'h00, "R9 final");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule